// File: doc/BRIEF.md
# Asynchronous Static RAM Controller with Byte Lanes

This block sits between a synchronous request stream and an external asynchronous static RAM organised as 1M words of 16 bits. The RAM has one active-low and one active-high chip select, separate active-low write and output enables, and one active-low enable for each byte of the data word. A user issues a word access on a valid/ready request port. The request carries a 20-bit word address, a write flag, 16 bits of write data and a 2-bit lane mask. Read results come back on a response port as a one-cycle valid strobe with data. The response port has no back-pressure. The request port applies back-pressure by holding `req_ready` low until the current memory cycle has fully elapsed. A request that is held valid while `req_ready` is low stays pending, and it is accepted at the first clock edge where both signals are high.

Every phase of the memory cycle is a whole number of clocks. Each count is derived at elaboration from the clock period `CLK_NS` and a speed-grade parameter, rounding up. Writes are controlled by the write enable. The output enable stays high for the whole write. The controller turns its own data drivers on only after the write enable has fallen and after the RAM's outputs have had time to float. It turns them off one clock after the write enable rises. Between accesses the RAM is left selected with its outputs disabled.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is active, and for `INIT_CYCLES` (default 4) clocks after its release, the memory pins are parked: chip-select-low pin high, chip-select-high pin low, write and output enables high, both lane enables high, and data drive off. `req_ready` is low during this time.
- R2: When no access is in progress, the pins show the selected-but-output-disabled state: chip-select-low pin low, chip-select-high pin high, write and output enables high, both lane enables low, and data drive off. `req_ready` is high in this state.
- R3: A request is taken at a clock edge where `req_valid` and `req_ready` are both high. `req_ready` then stays low for the whole access window: 6 cycles for a write or a read with the default 10 ns clock and fast grade. It is high again in the cycle after the window.
- R4: A write drives the write enable low for the first 5 cycles of its 6-cycle window, starting in the cycle right after acceptance. The output enable stays high and the address stays stable for the whole window.
- R5: Mask bit 0 selects the low byte (data bits 7:0) and mask bit 1 selects the high byte (bits 15:8). A selected lane's enable is low for the whole access window. An unselected lane's enable is high for the whole window, so that lane is not written. A write with mask 00 changes no stored data.
- R6: The data drivers are on only from window cycle 1 through window cycle 5, which is the cycle in which the write enable has just risen. While they are on, they carry the accepted write data. This gives at least 25 ns of data setup before the write enable rises.
- R7: A read holds the output enable low and the write enable high for its whole 6-cycle window, with the accepted address on the bus.
- R8: Read data is sampled at the clock edge that ends the read window. In the next cycle it is returned with `rsp_valid` high for exactly one cycle. The bits of unselected lanes read as zero.
- R9: The controller never drives the data bus while the output enable is low. It also does not drive the bus within the RAM's output turn-off time (20 ns) after the output enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period `CLK_NS` |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_addr | input | 20 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | Read data valid, one-cycle pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 20 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_ce2 | output | 1 | RAM chip select, active high |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_lb_n | output | 1 | RAM low-byte enable, active low |
| mem_ub_n | output | 1 | RAM high-byte enable, active low |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data from the RAM bus |

## Verification
The assertions assume that reset is applied from the first clock. They also assume that the request fields are stable on the edge where the handshake completes. They take no position on what the RAM returns on `mem_dq_in`. The turn-off check counts cycles from the output-enable rise on the controller's own pins, so it holds whatever the data inputs do. The stimulus changes request fields only on falling edges. It keeps `req_valid` asserted through back-pressure until the handshake completes. A pin-level RAM model drives `mem_dq_in` only with the access delay modelled, and it puts poison values on lanes that are disabled or not yet valid.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_WR   = 2'd2,
    ST_RD   = 2'd3
  } seq_st_t;

  typedef struct packed {
    logic ce_n;
    logic ce2;
    logic oe_n;
    logic we_n;
    logic dq_oe;
  } ctl_pins_t;

  // nanoseconds to clocks, rounding up
  function automatic int ns_to_clk(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_lane_rcap.sv
module sram_lane_rcap #(
  parameter int DW = 16,
  parameter int NL = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [NL-1:0] lane_sel,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  localparam int LW = DW / NL;

  logic [DW-1:0] masked;

  // clear every lane that was not enabled on the bus
  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign masked[g*LW +: LW] = lane_sel[g] ? dq_in[g*LW +: LW] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= cap_en;
      if (cap_en) rsp_rdata <= masked;
    end
  end
endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
  import sram_lane_pkg::*;
#(
  parameter int CW       = 4,
  parameter int INIT_CYC = 4,
  parameter int WR_CYC   = 6,
  parameter int RD_CYC   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  output logic          accept,
  output seq_st_t       st_nxt,
  output logic [CW-1:0] cnt_nxt,
  output logic          rd_last
);
  localparam logic [CW-1:0] INIT_LAST = CW'(INIT_CYC - 1);
  localparam logic [CW-1:0] WR_LAST   = CW'(WR_CYC - 1);
  localparam logic [CW-1:0] RD_LAST   = CW'(RD_CYC - 1);

  seq_st_t       st_q;
  logic [CW-1:0] cnt_q;

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign rd_last   = (st_q == ST_RD) && (cnt_q == RD_LAST);

  always_comb begin
    st_nxt  = st_q;
    cnt_nxt = cnt_q + 1'b1;
    unique case (st_q)
      ST_INIT: if (cnt_q == INIT_LAST) begin
        st_nxt  = ST_IDLE;
        cnt_nxt = '0;
      end
      ST_IDLE: begin
        cnt_nxt = '0;
        if (req_valid) st_nxt = req_write ? ST_WR : ST_RD;
      end
      ST_WR: if (cnt_q == WR_LAST) begin
        st_nxt  = ST_IDLE;
        cnt_nxt = '0;
      end
      ST_RD: if (cnt_q == RD_LAST) begin
        st_nxt  = ST_IDLE;
        cnt_nxt = '0;
      end
      default: begin
        st_nxt  = ST_INIT;
        cnt_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_INIT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_nxt;
      cnt_q <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sram_lane_pins.sv
module sram_lane_pins
  import sram_lane_pkg::*;
#(
  parameter int AW        = 20,
  parameter int DW        = 16,
  parameter int NL        = 2,
  parameter int CW        = 4,
  parameter int WP_CYC    = 5,
  parameter int DRV_START = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [NL-1:0] req_mask,
  input  seq_st_t       st_nxt,
  input  logic [CW-1:0] cnt_nxt,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dq_out,
  output logic [NL-1:0] lane_sel,
  output ctl_pins_t     ctl_q,
  output logic [NL-1:0] lane_n_q
);
  localparam logic [CW-1:0] WP_END  = CW'(WP_CYC);
  localparam logic [CW-1:0] DRV_BEG = CW'(DRV_START);

  localparam ctl_pins_t PARK = '{ce_n: 1'b1, ce2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};
  localparam ctl_pins_t SEL  = '{ce_n: 1'b0, ce2: 1'b1, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

  logic [NL-1:0] sel_nxt;
  ctl_pins_t     ctl_nxt;
  logic [NL-1:0] lane_n_nxt;

  assign sel_nxt = accept ? req_mask : lane_sel;

  always_comb begin
    ctl_nxt    = SEL;
    lane_n_nxt = '0;
    unique case (st_nxt)
      ST_INIT: begin
        ctl_nxt    = PARK;
        lane_n_nxt = '1;
      end
      ST_WR: begin
        ctl_nxt.we_n  = (cnt_nxt >= WP_END);
        ctl_nxt.dq_oe = (cnt_nxt >= DRV_BEG) && (cnt_nxt <= WP_END);
        lane_n_nxt    = ~sel_nxt;
      end
      ST_RD: begin
        ctl_nxt.oe_n = 1'b0;
        lane_n_nxt   = ~sel_nxt;
      end
      default: begin
        ctl_nxt    = SEL;
        lane_n_nxt = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q      <= PARK;
      lane_n_q   <= '1;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      lane_sel   <= '0;
    end else begin
      ctl_q    <= ctl_nxt;
      lane_n_q <= lane_n_nxt;
      if (accept) begin
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
        lane_sel   <= req_mask;
      end
    end
  end
endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int CLK_NS      = 10,
  parameter int SLOW_GRADE  = 0,
  parameter int INIT_CYCLES = 4,
  parameter int AW          = 20,
  parameter int DW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_mask,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_ce2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_lb_n,
  output logic          mem_ub_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int NL = 2;

  // part timing in ns
  localparam int T_CYC = SLOW_GRADE ? 70 : 55;
  localparam int T_WP  = SLOW_GRADE ? 55 : 45;
  localparam int T_AW  = SLOW_GRADE ? 60 : 50;
  localparam int T_DS  = SLOW_GRADE ? 30 : 25;
  localparam int T_OEA = SLOW_GRADE ? 35 : 30;
  localparam int T_HZ  = SLOW_GRADE ? 25 : 20;

  localparam int CYC_CYC = ns_to_clk(T_CYC, CLK_NS);
  localparam int WP_RAW  = ns_to_clk(T_WP, CLK_NS);
  localparam int AW_CYC  = ns_to_clk(T_AW, CLK_NS);
  localparam int DS_CYC  = ns_to_clk(T_DS, CLK_NS);
  localparam int OEA_CYC = ns_to_clk(T_OEA, CLK_NS);
  localparam int HZ_CYC  = ns_to_clk(T_HZ, CLK_NS);

  localparam int DRV_START = imax(1, HZ_CYC - 1);
  localparam int WP_CYC    = imax(imax(WP_RAW, AW_CYC), DRV_START + DS_CYC);
  localparam int WR_CYC    = imax(CYC_CYC, WP_CYC + 1);
  localparam int RD_CYC    = imax(CYC_CYC, OEA_CYC);
  localparam int CNT_TOP   = imax(imax(WR_CYC, RD_CYC), INIT_CYCLES);
  localparam int CW        = $clog2(CNT_TOP + 1);

  logic          accept;
  seq_st_t       st_nxt;
  logic [CW-1:0] cnt_nxt;
  logic          rd_last;
  logic [NL-1:0] lane_sel;
  logic [NL-1:0] lane_n;
  ctl_pins_t     ctl;

  sram_lane_seq #(
    .CW(CW), .INIT_CYC(INIT_CYCLES), .WR_CYC(WR_CYC), .RD_CYC(RD_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_ready(req_ready), .accept(accept), .st_nxt(st_nxt),
    .cnt_nxt(cnt_nxt), .rd_last(rd_last)
  );

  sram_lane_pins #(
    .AW(AW), .DW(DW), .NL(NL), .CW(CW), .WP_CYC(WP_CYC), .DRV_START(DRV_START)
  ) u_pins (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_mask(req_mask), .st_nxt(st_nxt),
    .cnt_nxt(cnt_nxt), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .lane_sel(lane_sel), .ctl_q(ctl), .lane_n_q(lane_n)
  );

  sram_lane_rcap #(
    .DW(DW), .NL(NL)
  ) u_rcap (
    .clk(clk), .rst_n(rst_n), .cap_en(rd_last), .lane_sel(lane_sel),
    .dq_in(mem_dq_in), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  assign mem_ce_n  = ctl.ce_n;
  assign mem_ce2   = ctl.ce2;
  assign mem_oe_n  = ctl.oe_n;
  assign mem_we_n  = ctl.we_n;
  assign mem_dq_oe = ctl.dq_oe;
  assign mem_lb_n  = lane_n[0];
  assign mem_ub_n  = lane_n[1];
endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int HZ_CYC = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_ce2,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_lb_n,
  input logic          mem_ub_n,
  input logic          mem_dq_oe
);
  localparam int HW = $clog2(HZ_CYC + 2);

  // cycles since the output enable last went high, saturating
  logic [HW-1:0] oe_hi_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_hi_cnt <= HW'(HZ_CYC);
    else if (!mem_oe_n) oe_hi_cnt <= '0;
    else if (oe_hi_cnt < HW'(HZ_CYC)) oe_hi_cnt <= oe_hi_cnt + 1'b1;
  end

  assert_parked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce2 |-> (mem_ce_n && !req_ready && !mem_dq_oe && mem_lb_n && mem_ub_n));

  assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_ce_n && mem_ce2 && mem_oe_n && mem_we_n &&
                   !mem_lb_n && !mem_ub_n && !mem_dq_oe));

  assert_busy_after_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_we_excl_oe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_addr));

  assert_drive_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (!mem_we_n || !$past(mem_we_n)));

  assert_rsp_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_oe_n && (oe_hi_cnt >= HW'(HZ_CYC))));
endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(
  .AW(AW), .DW(DW), .HZ_CYC(HZ_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
  .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
  .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_lane_ctrl_test.sv
module sram_lane_ctrl_test;
  localparam int CLK = 10;
  localparam int INIT = 4;
  localparam int WIN = 6;      // write and read window, R3
  localparam int WE_LOW = 5;   // R4
  localparam int T_ACC = 55, T_WP = 45, T_DS = 25, T_HZ = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] mem_addr;
  logic        mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
  logic [15:0] mem_dq_out;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_in = 16'hA5A5;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK/2) clk = ~clk;

  sram_lane_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n),
    .mem_ub_n(mem_ub_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  // ---------------- reference model (request level) ----------------
  logic [15:0] ref_mem [int];
  int          busy = INIT;
  int          op = 0;          // 0 none, 1 write, 2 read
  int          op_idx = 0;
  logic [19:0] op_addr = '0;
  logic [1:0]  op_mask = '0;
  logic [15:0] op_data = '0;
  int          rsp_wait = 0;
  logic [15:0] pend = '0;
  bit          exp_rv = 1'b0;
  logic [15:0] exp_rd = '0;

  function automatic logic [15:0] lane_keep(input logic [15:0] d, input logic [1:0] m);
    return {m[1] ? d[15:8] : 8'h00, m[0] ? d[7:0] : 8'h00};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      busy = INIT; op = 0; rsp_wait = 0; exp_rv = 1'b0;
    end else begin
      exp_rv = 1'b0;
      if (rsp_wait > 0) begin
        rsp_wait--;
        if (rsp_wait == 0) begin exp_rv = 1'b1; exp_rd = pend; end
      end
      if (busy > 0) begin
        busy--; op_idx++;
        if (busy == 0) op = 0;
      end else if (req_valid) begin
        busy = WIN; op_idx = 0; op_addr = req_addr; op_mask = req_mask;
        op_data = req_wdata;
        if (req_write) begin
          logic [15:0] old;
          op = 1;
          old = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 16'h0;
          ref_mem[int'(req_addr)] = {req_mask[1] ? req_wdata[15:8] : old[15:8],
                                      req_mask[0] ? req_wdata[7:0] : old[7:0]};
        end else begin
          op = 2;
          rsp_wait = WIN;
          pend = lane_keep(ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 16'h0,
                           req_mask);
        end
      end
    end
  end

  // ---------------- per-clock comparison ----------------
  always @(negedge clk) begin
    if (!done) begin
      check(req_ready == (rst_n && busy == 0), "R3 ready", req_ready, rst_n && busy == 0);
      check(rsp_valid == exp_rv, "R8 rsp_valid", rsp_valid, exp_rv);
      if (exp_rv) check(rsp_rdata == exp_rd, "R8 rsp_rdata", rsp_rdata, exp_rd);
      if (!rst_n || (busy > 0 && op == 0)) begin
        check(mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n
              && !mem_dq_oe, "R1 parked pins",
              {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe},
              7'b1011110);
      end else if (busy == 0) begin
        check(!mem_ce_n && mem_ce2 && mem_oe_n && mem_we_n && !mem_lb_n && !mem_ub_n
              && !mem_dq_oe, "R2 idle pins",
              {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe},
              7'b0111000);
      end else begin
        check({mem_ub_n, mem_lb_n} == ~op_mask, "R5 lane enables",
              {mem_ub_n, mem_lb_n}, ~op_mask);
        check(mem_addr == op_addr && !mem_ce_n && mem_ce2, "R4/R7 address and select",
              mem_addr, op_addr);
        if (op == 1) begin
          check(mem_we_n == !(op_idx < WE_LOW) && mem_oe_n, "R4 write strobe",
                {mem_we_n, mem_oe_n}, {!(op_idx < WE_LOW), 1'b1});
          check(mem_dq_oe == (op_idx >= 1 && op_idx <= WE_LOW), "R6 drive window",
                mem_dq_oe, op_idx >= 1 && op_idx <= WE_LOW);
          if (mem_dq_oe) check(mem_dq_out == op_data, "R6 drive data", mem_dq_out, op_data);
        end else begin
          check(!mem_oe_n && mem_we_n && !mem_dq_oe, "R7 read strobes",
                {mem_oe_n, mem_we_n, mem_dq_oe}, 3'b010);
        end
      end
    end
  end

  // ---------------- pin-level RAM model ----------------
  logic [15:0] ram [int];
  int          rd_age = 0;
  bit          prev_rdc = 1'b0;
  logic [19:0] prev_addr = '0;
  int          we_age = 0, ds_age = 0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_lanes = '0;
  logic [19:0] wr_addr = '0;
  int          oe_hi_age = 100;

  always @(negedge clk) begin
    bit sel, rdc;
    logic [15:0] word;
    sel = !mem_ce_n && mem_ce2;
    rdc = sel && !mem_oe_n && mem_we_n && (!mem_lb_n || !mem_ub_n);
    rd_age = (rdc && prev_rdc && mem_addr == prev_addr) ? rd_age + 1 : (rdc ? 1 : 0);
    prev_rdc = rdc; prev_addr = mem_addr;
    word = ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 16'h0;
    if (rdc && rd_age * CLK >= T_ACC)
      mem_dq_in = {!mem_ub_n ? word[15:8] : 8'h5A, !mem_lb_n ? word[7:0] : 8'h5A};
    else
      mem_dq_in = 16'hA5A5;

    oe_hi_age = mem_oe_n ? oe_hi_age + 1 : 0;
    if (mem_dq_oe && !done)
      check(mem_oe_n && (oe_hi_age - 1) * CLK >= T_HZ, "R9 bus turnaround",
            oe_hi_age, T_HZ / CLK + 1);

    if (sel && !mem_we_n) begin
      we_age++;
      if (mem_dq_oe) begin ds_age++; wr_data = mem_dq_out; end else ds_age = 0;
      wr_lanes = {!mem_ub_n, !mem_lb_n};
      wr_addr = mem_addr;
    end else if (we_age > 0) begin
      logic [15:0] old;
      check(we_age * CLK >= T_WP, "R4 write pulse width", we_age * CLK, T_WP);
      check(ds_age * CLK >= T_DS, "R6 data setup", ds_age * CLK, T_DS);
      old = ram.exists(int'(wr_addr)) ? ram[int'(wr_addr)] : 16'h0;
      ram[int'(wr_addr)] = {wr_lanes[1] ? wr_data[15:8] : old[15:8],
                            wr_lanes[0] ? wr_data[7:0] : old[7:0]};
      we_age = 0; ds_age = 0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input bit wr, input logic [19:0] a, input logic [15:0] d,
                        input logic [1:0] m);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R5: full, partial and empty lane masks on one word
    do_req(1, 20'h00010, 16'h1234, 2'b11);
    do_req(0, 20'h00010, 16'h0000, 2'b11);
    do_req(1, 20'h00010, 16'hABCD, 2'b01);
    do_req(0, 20'h00010, 16'h0000, 2'b11);
    do_req(1, 20'h00010, 16'h77EE, 2'b10);
    do_req(0, 20'h00010, 16'h0000, 2'b10);
    do_req(0, 20'h00010, 16'h0000, 2'b01);
    do_req(1, 20'h00010, 16'hFFFF, 2'b00);
    do_req(0, 20'h00010, 16'h0000, 2'b11);
    do_req(0, 20'h00010, 16'h0000, 2'b00);
    // address extremes
    do_req(1, 20'hFFFFF, 16'hC0DE, 2'b11);
    do_req(1, 20'h00000, 16'h0F0F, 2'b11);
    do_req(0, 20'hFFFFF, 16'h0000, 2'b11);
    do_req(0, 20'h00000, 16'h0000, 2'b11);
    // back-to-back mixed traffic
    for (int i = 0; i < 16; i++)
      do_req(1, 20'(i * 4099), 16'(i * 16'h1357 + 3), 2'(i % 4));
    for (int i = 0; i < 16; i++) begin
      do_req(0, 20'(i * 4099), 16'h0, 2'b11);
      do_req(1, 20'(i * 4099 + 1), 16'(~i), 2'b11);
    end
    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule